// File: doc/BRIEF.md
# Converter-side serial frame sequencer

This block is the digital half of a voice-band converter's serial port, seen from the converter. It divides the master clock by four to make the shift clock, and it generates the transmit and receive frame syncs and the end-of-data strobes. It shifts a receive word out on the data-receive line and gathers a transmit word from the data-transmit line. A processor at the far end uses these lines as an ordinary synchronous serial link. Frames start from one-cycle request strobes. There is one strobe for a transmit frame and one for a receive frame. The transmit strobe carries a flag that marks the transfer as secondary, meaning control only.

A mode pin chooses between two framings. Word framing sends one 16-bit word per frame. Byte framing sends two 8-bit halves. Between the halves the end-of-data line stays low, so the peer can tell which half came first, and the frame sync rises for a short gap. A control bit, loaded by a write strobe, chooses synchronous or asynchronous operation. In synchronous operation the receive side follows every primary transmit frame exactly. A secondary transfer produces no receive framing at all. In asynchronous operation the two sides are launched independently by their own strobes.

Top module: `vbc_serial_framer`

## Requirements
- R1: `sclk` is `mclk` divided by four. It is low for two master cycles and then high for two. Reset leaves it low.
- R2: Word framing (`byte_mode`=0). The frame sync is low for exactly 16 shift-clock periods. It then returns high, and in that same period the end-of-data line is low for exactly one shift-clock period before it returns high.
- R3: Byte framing (`byte_mode`=1). The frame sync is low for 8 periods. It is then high for 4 periods, during which end-of-data goes low. The sync is low again for the 8 periods of the second half, with end-of-data still low. End-of-data then returns high while the sync stays low for one more period, and after that the sync goes high.
- R4: `dr` sends the receive word MSB first and changes only on a rising `sclk` edge. Bit 15 is already on `dr` in the period before `fsr_n` falls. In byte framing the second half starts with bit 7. `dr` is 0 when no receive frame is running.
- R5: `dx` is sampled on falling `sclk` edges while the transmit frame sync is low, MSB first. At the end of the transmit frame the assembled word appears on `tx_word`, and `tx_word_valid` is high for exactly one `mclk` cycle.
- R6: In synchronous mode a primary transmit frame also frames the receive side. `fsr_n`/`eodr_n` match `fsx_n`/`eodx_n` period for period. `rx_req` has no effect.
- R7: In synchronous mode a secondary transfer (`tx_secondary`=1 with `tx_req`) frames only the transmit side, and `fsr_n` and `eodr_n` stay high. `frame_secondary` is 1 for the duration of a secondary transmit frame and 0 during a primary one.
- R8: In asynchronous mode `tx_req` frames only the transmit lines and `rx_req` frames only the receive lines.
- R9: While `rst_n` is low, all four framing outputs are high, `dr`, `tx_word`, `tx_word_valid` and `frame_secondary` are 0, and asynchronous mode is selected.
- R10: The mode bit is loaded from `ctl_sync` only on a cycle with `ctl_wr`=1 (1 = synchronous, 0 = asynchronous). A change of `ctl_sync` without `ctl_wr` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| byte_mode | input | 1 | 1 = two-byte framing, 0 = word framing; sampled at frame launch |
| ctl_wr | input | 1 | Strobe that loads `ctl_sync` |
| ctl_sync | input | 1 | 1 = synchronous, 0 = asynchronous |
| tx_req | input | 1 | Request a transmit frame |
| tx_secondary | input | 1 | Marks the requested transmit frame as secondary |
| rx_req | input | 1 | Request a receive frame (asynchronous mode only) |
| rx_word | input | DATA_W | Receive word, loaded at frame launch |
| dx | input | 1 | Serial data from the peer |
| sclk | output | 1 | Shift clock |
| fsx_n | output | 1 | Transmit frame sync, active low |
| eodx_n | output | 1 | Transmit end-of-data, active low |
| fsr_n | output | 1 | Receive frame sync, active low |
| eodr_n | output | 1 | Receive end-of-data, active low |
| dr | output | 1 | Serial data to the peer |
| frame_secondary | output | 1 | Current transmit frame is secondary |
| tx_word | output | DATA_W | Last word gathered from `dx` |
| tx_word_valid | output | 1 | One-cycle strobe for `tx_word` |

## Verification
The bench acts as the peer on the serial lines. Every shift-clock period it logs the four strobes and compares the sequence with the slot pattern each framing should produce. A design that let the frame sync rise one period early, or that released end-of-data before the last byte, would fail on those slots. Word values such as 8000, 0001, FFFF and 0000 in byte framing expose a swapped half or a bit sent one period late, because the reassembled word no longer matches. Secondary transfers in synchronous mode, and receive strobes issued in synchronous mode, catch a receive side that frames when it must stay quiet. Writing `ctl_sync` without the strobe catches a mode bit that follows the pin rather than the write.

// File: rtl/vbc_pkg.sv
`timescale 1ns/1ps
package vbc_pkg;

   // Decoded meaning of one shift-clock period within a frame
   typedef struct packed {
      logic fs_low;    // frame sync asserted
      logic eod_low;   // end-of-data asserted
      logic bit_slot;  // a data bit is exchanged in this period
      logic drive;     // serial output shows a data bit
   } slot_flags_t;

endpackage

// File: rtl/vbc_clk_div.sv
`timescale 1ns/1ps
module vbc_clk_div #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic sclk,
   output logic rise_tick,
   output logic fall_tick
);
   localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;
   localparam int HALF = DIV / 2;

   logic [PW-1:0] ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   ph <= '0;
      else if (ph == PW'(DIV - 1))  ph <= '0;
      else                          ph <= ph + 1'b1;
   end

   // sclk is high in the upper half of the phase count
   assign sclk      = (ph >= PW'(HALF));
   assign rise_tick = (ph == PW'(HALF - 1));
   assign fall_tick = (ph == PW'(DIV - 1));
endmodule

// File: rtl/vbc_frame_engine.sv
`timescale 1ns/1ps
module vbc_frame_engine
   import vbc_pkg::*;
#(
   parameter  int DATA_W    = 16,
   parameter  int GAP_SLOTS = 4,
   localparam int IW        = $clog2(DATA_W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rise_tick,
   input  logic          go,
   input  logic          byte_mode,
   input  logic          sec_in,
   output logic          busy,
   output logic          fs_n,
   output logic          eod_n,
   output logic          bit_slot,
   output logic          drive,
   output logic [IW-1:0] bit_idx,
   output logic          frame_end,
   output logic          sec_out
);
   localparam int BW       = DATA_W / 2;
   localparam int W_LAST   = DATA_W + 1;
   localparam int B_GAP_LO = BW + 1;
   localparam int B_GAP_HI = BW + GAP_SLOTS;
   localparam int B2_LO    = B_GAP_HI + 1;
   localparam int B2_HI    = DATA_W + GAP_SLOTS;
   localparam int B_LAST   = B2_HI + 1;
   localparam int SW       = $clog2(B_LAST + 1);

   logic          active, byte_q, sec_q;
   logic [SW-1:0] slot, last_slot;
   slot_flags_t   fl;
   int            idx, s_i;

   assign last_slot = byte_q ? SW'(B_LAST) : SW'(W_LAST);
   assign s_i       = int'(slot);

   // Slot sequencer: advances once per shift clock on its rising edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         slot   <= '0;
         byte_q <= 1'b0;
         sec_q  <= 1'b0;
      end else if (rise_tick) begin
         if (active) begin
            if (slot == last_slot) begin
               active <= 1'b0;
               sec_q  <= 1'b0;
            end else begin
               slot <= slot + 1'b1;
            end
         end else if (go) begin
            active <= 1'b1;
            slot   <= '0;
            byte_q <= byte_mode;
            sec_q  <= sec_in;
         end
      end
   end

   // Slot decode: period 0 presets the MSB, data periods follow
   always_comb begin
      fl  = '0;
      idx = 0;
      if (active) begin
         if (s_i == 0) begin
            fl.drive = 1'b1;
            idx      = DATA_W - 1;
         end else if (!byte_q) begin
            if (s_i <= DATA_W) begin
               fl.fs_low   = 1'b1;
               fl.bit_slot = 1'b1;
               fl.drive    = 1'b1;
               idx         = DATA_W - s_i;
            end else if (s_i == W_LAST) begin
               fl.eod_low = 1'b1;
            end
         end else begin
            if (s_i <= BW) begin
               fl.fs_low   = 1'b1;
               fl.bit_slot = 1'b1;
               fl.drive    = 1'b1;
               idx         = DATA_W - s_i;
            end else if (s_i >= B_GAP_LO && s_i <= B_GAP_HI) begin
               fl.eod_low = 1'b1;
               fl.drive   = 1'b1;
               idx        = BW - 1;
            end else if (s_i >= B2_LO && s_i <= B2_HI) begin
               fl.fs_low   = 1'b1;
               fl.eod_low  = 1'b1;
               fl.bit_slot = 1'b1;
               fl.drive    = 1'b1;
               idx         = B2_HI - s_i;
            end else if (s_i == B_LAST) begin
               fl.fs_low = 1'b1;
            end
         end
      end
   end

   assign busy      = active;
   assign fs_n      = ~fl.fs_low;
   assign eod_n     = ~fl.eod_low;
   assign bit_slot  = fl.bit_slot;
   assign drive     = fl.drive;
   assign bit_idx   = IW'(idx);
   assign frame_end = rise_tick && active && (slot == last_slot);
   assign sec_out   = active && sec_q;
endmodule

// File: rtl/vbc_dr_serializer.sv
`timescale 1ns/1ps
module vbc_dr_serializer #(
   parameter  int DATA_W = 16,
   localparam int IW     = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] word,
   input  logic              drive,
   input  logic [IW-1:0]     bit_idx,
   output logic              dr
);
   logic [DATA_W-1:0] hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hold <= '0;
      else if (load) hold <= word;
   end

   assign dr = drive & hold[bit_idx];
endmodule

// File: rtl/vbc_dx_capture.sv
`timescale 1ns/1ps
module vbc_dx_capture #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample,
   input  logic              ser_in,
   input  logic              frame_end,
   output logic [DATA_W-1:0] word,
   output logic              valid
);
   logic [DATA_W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr    <= '0;
         word  <= '0;
         valid <= 1'b0;
      end else begin
         if (sample) sr <= {sr[DATA_W-2:0], ser_in};
         valid <= frame_end;
         if (frame_end) word <= sr;
      end
   end
endmodule

// File: rtl/vbc_serial_framer.sv
`timescale 1ns/1ps
module vbc_serial_framer #(
   parameter int DATA_W    = 16,
   parameter int GAP_SLOTS = 4,
   parameter int MCLK_DIV  = 4
) (
   input  logic              mclk,
   input  logic              rst_n,
   input  logic              byte_mode,
   input  logic              ctl_wr,
   input  logic              ctl_sync,
   input  logic              tx_req,
   input  logic              tx_secondary,
   input  logic              rx_req,
   input  logic [DATA_W-1:0] rx_word,
   input  logic              dx,
   output logic              sclk,
   output logic              fsx_n,
   output logic              eodx_n,
   output logic              fsr_n,
   output logic              eodr_n,
   output logic              dr,
   output logic              frame_secondary,
   output logic [DATA_W-1:0] tx_word,
   output logic              tx_word_valid
);
   localparam int IW  = $clog2(DATA_W);
   localparam int TXE = 0;
   localparam int RXE = 1;

   if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("DATA_W must be even and at least 4");
   end
   if (MCLK_DIV < 2 || (MCLK_DIV % 2) != 0) begin : g_bad_div
      $error("MCLK_DIV must be even and at least 2");
   end
   if (GAP_SLOTS < 1) begin : g_bad_gap
      $error("GAP_SLOTS must be at least 1");
   end

   logic rise_tick, fall_tick;
   logic sync_q, tx_pend, tx_sec_pend, rx_pend;
   logic [1:0] go, busy, fs_v, eod_v, bit_v, drv_v, end_v, sec_v, sec_src;
   logic [IW-1:0] idx_v [2];

   vbc_clk_div #(.DIV(MCLK_DIV)) u_div (
      .clk(mclk), .rst_n(rst_n), .sclk(sclk),
      .rise_tick(rise_tick), .fall_tick(fall_tick)
   );

   // Mode bit: loaded only by the control write strobe
   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n)      sync_q <= 1'b0;
      else if (ctl_wr) sync_q <= ctl_sync;
   end

   // Launch decisions: the receive side follows primary transmit launches when synchronous
   always_comb begin
      go[TXE] = rise_tick && tx_pend && !busy[TXE];
      if (sync_q) go[RXE] = go[TXE] && !tx_sec_pend;
      else        go[RXE] = rise_tick && rx_pend && !busy[RXE];
   end

   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
         tx_pend     <= 1'b0;
         tx_sec_pend <= 1'b0;
         rx_pend     <= 1'b0;
      end else begin
         if (go[TXE]) tx_pend <= 1'b0;
         if (tx_req) begin
            tx_pend     <= 1'b1;
            tx_sec_pend <= tx_secondary;
         end
         if (sync_q) begin
            rx_pend <= 1'b0;
         end else begin
            if (go[RXE]) rx_pend <= 1'b0;
            if (rx_req)  rx_pend <= 1'b1;
         end
      end
   end

   assign sec_src = {1'b0, tx_sec_pend};

   for (genvar g = 0; g < 2; g++) begin : g_eng
      vbc_frame_engine #(.DATA_W(DATA_W), .GAP_SLOTS(GAP_SLOTS)) u_eng (
         .clk(mclk), .rst_n(rst_n), .rise_tick(rise_tick),
         .go(go[g]), .byte_mode(byte_mode), .sec_in(sec_src[g]),
         .busy(busy[g]), .fs_n(fs_v[g]), .eod_n(eod_v[g]),
         .bit_slot(bit_v[g]), .drive(drv_v[g]), .bit_idx(idx_v[g]),
         .frame_end(end_v[g]), .sec_out(sec_v[g])
      );
   end

   vbc_dr_serializer #(.DATA_W(DATA_W)) u_ser (
      .clk(mclk), .rst_n(rst_n), .load(go[RXE]), .word(rx_word),
      .drive(drv_v[RXE]), .bit_idx(idx_v[RXE]), .dr(dr)
   );

   vbc_dx_capture #(.DATA_W(DATA_W)) u_cap (
      .clk(mclk), .rst_n(rst_n), .sample(fall_tick && bit_v[TXE]),
      .ser_in(dx), .frame_end(end_v[TXE]),
      .word(tx_word), .valid(tx_word_valid)
   );

   logic unused_side;
   assign unused_side = ^{bit_v[RXE], drv_v[TXE], idx_v[TXE], end_v[RXE], sec_v[RXE]};

   assign fsx_n           = fs_v[TXE];
   assign eodx_n          = eod_v[TXE];
   assign fsr_n           = fs_v[RXE];
   assign eodr_n          = eod_v[RXE];
   assign frame_secondary = sec_v[TXE];
endmodule

// File: rtl/vbc_framer_checker.sv
`timescale 1ns/1ps
module vbc_framer_checker (
   input logic clk,
   input logic rst_n,
   input logic sclk,
   input logic fsx_n,
   input logic eodx_n,
   input logic fsr_n,
   input logic eodr_n,
   input logic dr,
   input logic frame_secondary,
   input logic tx_word_valid,
   input logic sync_q
);
   // R1: two master cycles high, two low
   a_r1_sclk_high_two: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |=> (sclk ##1 !sclk));
   a_r1_sclk_low_two: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |=> (!sclk ##1 sclk));

   // R2 / R3: end-of-data falls exactly as the frame sync rises
   a_r2_eodx_with_fsx_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eodx_n) |-> $rose(fsx_n));
   a_r3_eodr_with_fsr_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eodr_n) |-> $rose(fsr_n));

   // R4: the MSB is already on dr when the receive sync falls; sync edges follow sclk rises
   a_r4_msb_preset: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fsr_n) |-> $stable(dr));
   a_r4_fsr_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fsr_n) |-> $rose(sclk));

   // R5: the word strobe lasts one master cycle
   a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      tx_word_valid |=> !tx_word_valid);

   // R6: synchronous primary frames start both sides together
   a_r6_sync_together: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_q && $fell(fsx_n) && !frame_secondary) |-> $fell(fsr_n));

   // R7: no receive framing beside a secondary frame in synchronous mode
   a_r7_sec_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_q && frame_secondary) |-> (fsr_n && eodr_n));
endmodule

bind vbc_serial_framer vbc_framer_checker u_chk (
   .clk(mclk), .rst_n(rst_n), .sclk(sclk), .fsx_n(fsx_n), .eodx_n(eodx_n),
   .fsr_n(fsr_n), .eodr_n(eodr_n), .dr(dr), .frame_secondary(frame_secondary),
   .tx_word_valid(tx_word_valid), .sync_q(sync_q)
);

// File: tb/vbc_serial_framer_bench.sv
`timescale 1ns/1ps
module vbc_serial_framer_bench;
   logic        mclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_mode = 1'b0, ctl_wr = 1'b0, ctl_sync = 1'b0;
   logic        tx_req = 1'b0, tx_secondary = 1'b0, rx_req = 1'b0;
   logic [15:0] rx_word = '0;
   logic        dx = 1'b0;
   logic        sclk, fsx_n, eodx_n, fsr_n, eodr_n, dr, frame_secondary, tx_word_valid;
   logic [15:0] tx_word;

   vbc_serial_framer u_vbc_serial_framer (
      .mclk(mclk), .rst_n(rst_n), .byte_mode(byte_mode), .ctl_wr(ctl_wr),
      .ctl_sync(ctl_sync), .tx_req(tx_req), .tx_secondary(tx_secondary),
      .rx_req(rx_req), .rx_word(rx_word), .dx(dx), .sclk(sclk), .fsx_n(fsx_n),
      .eodx_n(eodx_n), .fsr_n(fsr_n), .eodr_n(eodr_n), .dr(dr),
      .frame_secondary(frame_secondary), .tx_word(tx_word),
      .tx_word_valid(tx_word_valid)
   );

   always #10 mclk = ~mclk;   // 50 MHz

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   // Peer model state
   logic [5:0]  lg [0:63];   // {sec, fsx_n, eodx_n, fsr_n, eodr_n, dr}
   int          ln = 0;
   bit          log_en = 0;
   logic        prev_sclk = 1'b0;
   logic [15:0] dx_word = '0, rbuf = '0;
   int          dcnt = 0, rcnt = 0, vcnt = 0;

   always @(negedge mclk) begin
      if (sclk && !prev_sclk) begin
         if (log_en && ln < 64) begin
            lg[ln] = {frame_secondary, fsx_n, eodx_n, fsr_n, eodr_n, dr};
            ln++;
         end
         if (!fsx_n && dcnt < 16) begin
            dx <= dx_word[15 - dcnt];
            dcnt++;
         end else if (fsx_n && eodx_n) begin
            dcnt = 0;
         end
      end
      if (!sclk && prev_sclk && !fsr_n && rcnt < 16) begin
         rbuf = {rbuf[14:0], dr};
         rcnt++;
      end
      if (tx_word_valid) vcnt++;
      prev_sclk = sclk;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Expected {fs_n, eod_n} for the k-th period counted from the first low sync period
   function automatic logic [1:0] exp_slot(input bit bm, input int k);
      if (!bm) begin
         if (k < 16)  return 2'b01;
         if (k == 16) return 2'b10;
         return 2'b11;
      end
      if (k < 8)   return 2'b01;
      if (k < 12)  return 2'b10;
      if (k < 20)  return 2'b00;
      if (k == 20) return 2'b01;
      return 2'b11;
   endfunction

   task automatic run_frame(input bit bm, input bit send_tx, input bit sec,
                            input bit send_rx, input logic [15:0] tw,
                            input logic [15:0] rw, input bit exp_tx,
                            input bit exp_rx, input bit locked, input string tag);
      int ftx, frx, len, mis;
      string fr;
      fr = bm ? "R3" : "R2";
      byte_mode = bm; rx_word = rw; dx_word = tw; tx_secondary = sec;
      @(negedge mclk);
      ln = 0; rcnt = 0; rbuf = '0; vcnt = 0; log_en = 1;
      tx_req = send_tx; rx_req = send_rx;
      @(negedge mclk);
      tx_req = 1'b0; rx_req = 1'b0;
      repeat (124) @(negedge mclk);
      log_en = 0;
      len = bm ? 22 : 18;
      ftx = -1; frx = -1;
      for (int i = 0; i < ln; i++) begin
         if (ftx < 0 && !lg[i][4]) ftx = i;
         if (frx < 0 && !lg[i][2]) frx = i;
      end
      if (exp_tx) begin
         check(ftx >= 1 && ftx + len <= ln, fr, {tag, " tx frame seen"}, ftx, 1);
         if (ftx >= 1 && ftx + len <= ln) begin
            mis = 0;
            for (int k = 0; k < len; k++)
               if (lg[ftx + k][4:3] != exp_slot(bm, k)) mis++;
            check(mis == 0, fr, {tag, " tx sync/eod slots"}, mis, 0);
            check(lg[ftx][5] == sec, "R7", {tag, " frame_secondary"}, lg[ftx][5], sec);
         end
         check(tx_word == tw, "R5", {tag, " tx_word"}, tx_word, tw);
         check(vcnt == 1, "R5", {tag, " valid cycles"}, vcnt, 1);
      end else begin
         check(ftx == -1 && vcnt == 0, "R8", {tag, " no tx frame"}, ftx, -1);
      end
      if (exp_rx) begin
         check(frx >= 1 && frx + len <= ln, fr, {tag, " rx frame seen"}, frx, 1);
         if (frx >= 1 && frx + len <= ln) begin
            mis = 0;
            for (int k = 0; k < len; k++)
               if (lg[frx + k][2:1] != exp_slot(bm, k)) mis++;
            check(mis == 0, fr, {tag, " rx sync/eod slots"}, mis, 0);
            check(lg[frx - 1][0] == rw[15], "R4", {tag, " MSB before fsr fall"},
                  lg[frx - 1][0], rw[15]);
            check(lg[frx + len - 1][0] == 1'b0, "R4", {tag, " dr idle"},
                  lg[frx + len - 1][0], 0);
         end
         check(rbuf == rw, "R4", {tag, " rx word on dr"}, rbuf, rw);
         if (locked) begin
            mis = 0;
            for (int i = 0; i < ln; i++)
               if (lg[i][4:3] != lg[i][2:1]) mis++;
            check(mis == 0 && frx == ftx, "R6", {tag, " rx follows tx"}, mis, 0);
         end
      end else begin
         mis = 0;
         for (int i = 0; i < ln; i++)
            if (lg[i][2:1] != 2'b11) mis++;
         check(mis == 0, sec ? "R7" : "R8", {tag, " rx quiet"}, mis, 0);
      end
   endtask

   task automatic write_ctl(input bit v);
      @(negedge mclk);
      ctl_sync = v; ctl_wr = 1'b1;
      @(negedge mclk);
      ctl_wr = 1'b0;
   endtask

   initial begin
      logic [3:0] seq;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge mclk);
      // R9: state while reset is held
      check(fsx_n && eodx_n && fsr_n && eodr_n, "R9", "framing outputs high",
            {fsx_n, eodx_n, fsr_n, eodr_n}, 4'hf);
      check(!dr && tx_word == 16'h0 && !tx_word_valid && !frame_secondary && !sclk,
            "R9", "data outputs zero", {dr, tx_word_valid, frame_secondary, sclk}, 0);
      rst_n = 1'b1;
      @(negedge mclk);
      // R1: shift clock shape
      for (int i = 0; i < 4; i++) begin
         @(negedge mclk);
         seq[i] = sclk;
      end
      check(seq == 4'b1100 || seq == 4'b0110 || seq == 4'b0011 || seq == 4'b1001,
            "R1", "sclk pattern", seq, 4'b1100);

      // R8 / R9: asynchronous after reset
      run_frame(0, 1, 0, 0, 16'hA5C3, 16'h0, 1, 0, 0, "async tx word");
      run_frame(1, 0, 0, 1, 16'h0, 16'h8001, 0, 1, 0, "async rx byte");
      run_frame(0, 0, 0, 1, 16'h0, 16'h7E18, 0, 1, 0, "async rx word");
      run_frame(1, 1, 0, 0, 16'h8000, 16'h0, 1, 0, 0, "async tx byte");

      // R10: pin change without strobe keeps asynchronous mode
      ctl_sync = 1'b1;
      run_frame(0, 1, 0, 0, 16'h1234, 16'h4321, 1, 0, 0, "R10 no strobe");
      write_ctl(1);
      run_frame(0, 1, 0, 0, 16'hFFFF, 16'h0001, 1, 1, 1, "R10 sync word");

      // R6: receive strobe ignored when synchronous
      run_frame(0, 0, 0, 1, 16'h0, 16'hBEEF, 0, 0, 0, "R6 rx_req ignored");
      // R7: secondary transfers
      run_frame(0, 1, 1, 0, 16'h0F0F, 16'hFFFF, 1, 0, 0, "R7 sec word");
      run_frame(1, 1, 1, 0, 16'hF00F, 16'hFFFF, 1, 0, 0, "R7 sec byte");
      // Byte corner values
      run_frame(1, 1, 0, 0, 16'h8000, 16'h0001, 1, 1, 1, "sync byte 8000");
      run_frame(1, 1, 0, 0, 16'hFFFF, 16'h0000, 1, 1, 1, "sync byte ffff");
      run_frame(1, 1, 0, 0, 16'h0001, 16'h8000, 1, 1, 1, "sync byte 0001");

      // Random synchronous traffic
      for (int n = 0; n < 20; n++) begin
         bit bm, sc;
         logic [15:0] tw, rw;
         bm = 1'($urandom);
         sc = ($urandom % 4) == 0;
         tw = 16'($urandom);
         rw = 16'($urandom);
         run_frame(bm, 1, sc, 0, tw, rw, 1, !sc, !sc, "random sync");
      end

      // R10: back to asynchronous
      write_ctl(0);
      run_frame(0, 1, 0, 0, 16'h5A5A, 16'h9999, 1, 0, 0, "R10 async again");
      run_frame(1, 0, 0, 1, 16'h0, 16'hC33C, 0, 1, 0, "R8 rx only");

      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge mclk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule